// File: doc/BRIEF.md
# Parity-Checked Character Load Controller

This block is the manual and tape load path of a serial computer. An operator or a tape reader presents one character at a time on five lines and marks it with a pair of complementary timing strobes. Once a fill request has put the controller into its load wait state, each accepted character is checked for odd parity. Good octal digits are shifted into a holding register. Two control codes move the assembled word either into the instruction register or into the accumulator.

A master reset puts the controller into an idle state. On word-timing pulses it then moves into a halt interlock and alternates between that interlock and a prepare-to-load state. A fill request seen on a word-timing pulse switches it to the wait state. The strobes arrive from outside the clock domain and are synchronised internally. The character lines travel through the same synchroniser stages, so the sampled character stays aligned with the strobe edge that selects it.

Top module: `charLoadCtl`

## Requirements
- R1: After reset (rstN low or masterReset high), holdReg, instrReg and accReg are zero, parityErr is 0 and loadMode is 0 (idle).
- R2: loadMode encodes idle=0, halt interlock=1, prepare=2, wait=3. Each wordTick pulse without fillReq moves idle to halt, halt to prepare, and prepare back to halt.
- R3: When fillReq is high at a wordTick in halt or prepare, the mode becomes wait. Without a wordTick, fillReq does not change the mode. Wait is left only through a reset.
- R4: A character is taken only when strobeP falls and strobeN rises together. A transition on one strobe alone takes no character.
- R5: The character is charLines[3:0], and charLines[4] is the parity line. A taken character whose five lines XOR to 0 sets parityErr and leaves all three registers unchanged.
- R6: A good character with bit 3 clear is an octal digit. Its bits [2:0] enter holdReg at the least significant end, earlier digits move up by three bits, and bits shifted past the top are lost.
- R7: The good code 4'b1001 (Location) copies holdReg into instrReg.
- R8: The good code 4'b1010 (Enter) copies holdReg into accReg and increments instrReg by one, modulo 2^24.
- R9: Any other good code with bit 3 set changes no register.
- R10: fillReq high clears parityErr on the next clock edge.
- R11: Characters taken while the mode is not wait change no register and no error flag.
- R12: masterReset from the wait state returns the mode to idle and clears all registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| charLines | input | 5 | Character lines: [3:0] code, [4] odd parity |
| strobeP | input | 1 | Primed timing strobe, high while the character is held |
| strobeN | input | 1 | Complement timing strobe |
| masterReset | input | 1 | Synchronous master reset of the controller |
| fillReq | input | 1 | Fill request: enters load wait, clears the parity error |
| wordTick | input | 1 | One-cycle word-timing pulse |
| holdReg | output | 24 | Holding register contents |
| instrReg | output | 24 | Instruction register contents |
| accReg | output | 24 | Accumulator contents |
| parityErr | output | 1 | Parity error flag |
| loadMode | output | 2 | Controller mode |

## Verification
Mode changes and the clearing of parityErr appear one edge after the wordTick, fillReq or masterReset cycle that causes them. The bench drives these inputs on the falling clock edge and checks at the next falling edge. A character reaches the registers three edges after the closing strobe transition: two synchroniser stages and one stage for edge detection. The bench therefore holds the lines steady and waits five cycles after the strobe closes before it samples. The strobe pair is opened and closed several cycles apart, so only the closing transition can produce a character.

// File: rtl/charLoadPkg.sv
package charLoadPkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_HALT = 2'd1,
    MODE_PREP = 2'd2,
    MODE_WAIT = 2'd3
  } loadMode_t;

  typedef struct packed {
    logic clearAll;
    logic shiftDigit;
    logic loadInstr;
    logic loadAcc;
    logic setErr;
    logic clrErr;
  } ctrlStrobes_t;

  localparam logic [3:0] CODE_LOCATION = 4'b1001;
  localparam logic [3:0] CODE_ENTER    = 4'b1010;

endpackage

// File: rtl/charStrobeSync.sv
module charStrobeSync #(
  parameter int CHAR_W = 5,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAR_W-1:0] charLines,
  input  logic              strobeP,
  input  logic              strobeN,
  output logic              charEvent,
  output logic [CHAR_W-1:0] charOut
);

  logic [STAGES-1:0] pSync, nSync;
  logic pPrev, nPrev;
  logic [CHAR_W-1:0] dSync [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pSync <= '0;
      nSync <= '1;
      pPrev <= 1'b0;
      nPrev <= 1'b1;
    end else begin
      pSync <= {pSync[STAGES-2:0], strobeP};
      nSync <= {nSync[STAGES-2:0], strobeN};
      pPrev <= pSync[STAGES-1];
      nPrev <= nSync[STAGES-1];
    end
  end

  // character lines follow the strobes through matching stages
  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) dSync[s] <= '0;
        else if (s == 0) dSync[s] <= charLines;
        else dSync[s] <= dSync[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign charEvent = pPrev && !pSync[STAGES-1] && !nPrev && nSync[STAGES-1];
  assign charOut   = dSync[STAGES-1];

  // R4
  single_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    charEvent |=> !charEvent);

endmodule

// File: rtl/loadCtl.sv
module loadCtl
  import charLoadPkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            masterReset,
  input  logic            fillReq,
  input  logic            wordTick,
  input  logic            charEvent,
  input  logic [CODE_W:0] charIn,
  output ctrlStrobes_t    ctrl,
  output loadMode_t       mode
);

  loadMode_t modeNext;
  logic parityOk, isControl, accept;
  logic [CODE_W-1:0] code;

  assign code      = charIn[CODE_W-1:0];
  assign parityOk  = ^charIn;
  assign isControl = code[CODE_W-1];
  assign accept    = charEvent && (mode == MODE_WAIT) && !masterReset;

  always_comb begin
    modeNext = mode;
    if (masterReset) modeNext = MODE_IDLE;
    else if (wordTick) begin
      unique case (mode)
        MODE_IDLE: modeNext = MODE_HALT;
        MODE_HALT: modeNext = fillReq ? MODE_WAIT : MODE_PREP;
        MODE_PREP: modeNext = fillReq ? MODE_WAIT : MODE_HALT;
        MODE_WAIT: modeNext = MODE_WAIT;
        default:   modeNext = MODE_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MODE_IDLE;
    else mode <= modeNext;
  end

  always_comb begin
    ctrl            = '0;
    ctrl.clearAll   = masterReset;
    ctrl.clrErr     = fillReq;
    ctrl.setErr     = accept && !parityOk;
    ctrl.shiftDigit = accept && parityOk && !isControl;
    ctrl.loadInstr  = accept && parityOk && (code == CODE_LOCATION[CODE_W-1:0]);
    ctrl.loadAcc    = accept && parityOk && (code == CODE_ENTER[CODE_W-1:0]);
  end

  // R5
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.shiftDigit, ctrl.loadInstr, ctrl.loadAcc, ctrl.setErr}));

  // R12
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    masterReset |=> mode == MODE_IDLE);

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_WAIT && !masterReset) |=> mode == MODE_WAIT);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_IDLE && !masterReset && !wordTick) |=> mode == MODE_IDLE);

endmodule

// File: rtl/loadDatapath.sv
module loadDatapath
  import charLoadPkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int DIGIT_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       ctrl,
  input  logic [DIGIT_W-1:0] digit,
  output logic [WORD_W-1:0]  holdReg,
  output logic [WORD_W-1:0]  instrReg,
  output logic [WORD_W-1:0]  accReg,
  output logic               parityErr
);

  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg   <= '0;
      instrReg  <= '0;
      accReg    <= '0;
      parityErr <= 1'b0;
    end else if (ctrl.clearAll) begin
      holdReg   <= '0;
      instrReg  <= '0;
      accReg    <= '0;
      parityErr <= 1'b0;
    end else begin
      if (ctrl.shiftDigit) holdReg <= {holdReg[WORD_W-DIGIT_W-1:0], digit};
      if (ctrl.loadInstr) instrReg <= holdReg;
      if (ctrl.loadAcc) begin
        accReg   <= holdReg;
        instrReg <= instrReg + ONE;
      end
      if (ctrl.clrErr) parityErr <= 1'b0;
      else if (ctrl.setErr) parityErr <= 1'b1;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.shiftDigit && !ctrl.clearAll) |=> $stable(holdReg));

  // R8
  enter_incr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadAcc && !ctrl.clearAll) |=> instrReg == WORD_W'($past(instrReg) + ONE));

  // R5
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.setErr && !ctrl.clrErr && !ctrl.clearAll) |=> parityErr);

  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clrErr |=> !parityErr);

endmodule

// File: rtl/charLoadCtl.sv
module charLoadCtl
  import charLoadPkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int DIGIT_W     = 3,
  parameter int CODE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W:0]   charLines,
  input  logic              strobeP,
  input  logic              strobeN,
  input  logic              masterReset,
  input  logic              fillReq,
  input  logic              wordTick,
  output logic [WORD_W-1:0] holdReg,
  output logic [WORD_W-1:0] instrReg,
  output logic [WORD_W-1:0] accReg,
  output logic              parityErr,
  output logic [1:0]        loadMode
);

  localparam int CHAR_W = CODE_W + 1;

  logic charEvent;
  logic [CHAR_W-1:0] charSync;
  ctrlStrobes_t ctrl;
  loadMode_t mode;

  charStrobeSync #(.CHAR_W(CHAR_W), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .charLines(charLines),
    .strobeP(strobeP), .strobeN(strobeN),
    .charEvent(charEvent), .charOut(charSync)
  );

  loadCtl #(.CODE_W(CODE_W)) uCtl (
    .clk(clk), .rstN(rstN), .masterReset(masterReset), .fillReq(fillReq),
    .wordTick(wordTick), .charEvent(charEvent), .charIn(charSync),
    .ctrl(ctrl), .mode(mode)
  );

  loadDatapath #(.WORD_W(WORD_W), .DIGIT_W(DIGIT_W)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .digit(charSync[DIGIT_W-1:0]),
    .holdReg(holdReg), .instrReg(instrReg), .accReg(accReg),
    .parityErr(parityErr)
  );

  assign loadMode = mode;

endmodule

// File: tb/sim_charLoadCtl.sv
`timescale 1ns/1ps
module sim_charLoadCtl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] charLines = '0;
  logic strobeP = 1'b0, strobeN = 1'b1;
  logic masterReset = 1'b0, fillReq = 1'b0, wordTick = 1'b0;
  logic [23:0] holdReg, instrReg, accReg;
  logic parityErr;
  logic [1:0] loadMode;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  charLoadCtl u0 (
    .clk(clk), .rstN(rstN), .charLines(charLines), .strobeP(strobeP),
    .strobeN(strobeN), .masterReset(masterReset), .fillReq(fillReq),
    .wordTick(wordTick), .holdReg(holdReg), .instrReg(instrReg),
    .accReg(accReg), .parityErr(parityErr), .loadMode(loadMode)
  );

  // {code, badParity, expHold, expInstr, expAcc, expErr}
  localparam logic [77:0] VEC [9] = '{
    {4'h7, 1'b0, 24'h000007, 24'h000000, 24'h000000, 1'b0},
    {4'h5, 1'b0, 24'h00003D, 24'h000000, 24'h000000, 1'b0},
    {4'h3, 1'b0, 24'h0001EB, 24'h000000, 24'h000000, 1'b0},
    {4'h9, 1'b0, 24'h0001EB, 24'h0001EB, 24'h000000, 1'b0},
    {4'hA, 1'b0, 24'h0001EB, 24'h0001EC, 24'h0001EB, 1'b0},
    {4'h1, 1'b1, 24'h0001EB, 24'h0001EC, 24'h0001EB, 1'b1},
    {4'hF, 1'b0, 24'h0001EB, 24'h0001EC, 24'h0001EB, 1'b1},
    {4'h2, 1'b0, 24'h000F5A, 24'h0001EC, 24'h0001EB, 1'b1},
    {4'hA, 1'b0, 24'h000F5A, 24'h0001ED, 24'h000F5A, 1'b1}
  };

  task automatic chk(input string req, input string what,
                     input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) wordTick = 1'b1;
    @(negedge clk) wordTick = 1'b0;
  endtask

  task automatic sendChar(input logic [3:0] code, input logic bad);
    @(negedge clk);
    charLines = {~(^code) ^ bad, code};
    strobeP = 1'b1; strobeN = 1'b0;
    repeat (4) @(negedge clk);
    strobeP = 1'b0; strobeN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic checkRegs(input string req, input logic [23:0] h,
                           input logic [23:0] i, input logic [23:0] a);
    chk(req, "holdReg", holdReg, h);
    chk(req, "instrReg", instrReg, i);
    chk(req, "accReg", accReg, a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkRegs("R1", 24'h0, 24'h0, 24'h0);
    chk("R1", "parityErr", {23'b0, parityErr}, 24'h0);
    chk("R1", "loadMode", {22'b0, loadMode}, 24'h0);

    // R2 mode sequence
    tick(); chk("R2", "idle->halt", {22'b0, loadMode}, 24'd1);
    tick(); chk("R2", "halt->prep", {22'b0, loadMode}, 24'd2);
    tick(); chk("R2", "prep->halt", {22'b0, loadMode}, 24'd1);

    // R11 character outside wait
    sendChar(4'h7, 1'b0);
    checkRegs("R11", 24'h0, 24'h0, 24'h0);

    // R3 fill without tick, then with tick
    @(negedge clk) fillReq = 1'b1;
    @(negedge clk) fillReq = 1'b0;
    chk("R3", "fill no tick", {22'b0, loadMode}, 24'd1);
    @(negedge clk) begin fillReq = 1'b1; wordTick = 1'b1; end
    @(negedge clk) begin fillReq = 1'b0; wordTick = 1'b0; end
    chk("R3", "enter wait", {22'b0, loadMode}, 24'd3);
    tick(); chk("R3", "wait holds", {22'b0, loadMode}, 24'd3);

    // table walk: R5 R6 R7 R8 R9
    for (int k = 0; k < 9; k++) begin
      sendChar(VEC[k][77:74], VEC[k][73]);
      checkRegs("R5/R6/R7/R8/R9 table", VEC[k][72:49], VEC[k][48:25], VEC[k][24:1]);
      chk("R5 table", "parityErr", {23'b0, parityErr}, {23'b0, VEC[k][0]});
    end

    // R10 fill clears error
    @(negedge clk) fillReq = 1'b1;
    @(negedge clk) fillReq = 1'b0;
    chk("R10", "parityErr", {23'b0, parityErr}, 24'h0);

    // R4 lone strobeP transition takes nothing
    @(negedge clk) begin charLines = {1'b0, 4'h4}; strobeP = 1'b1; end
    repeat (4) @(negedge clk);
    strobeP = 1'b0;
    repeat (5) @(negedge clk);
    chk("R4", "holdReg lone strobe", holdReg, 24'h000F5A);

    // R6 overflow: eight digits of 7 fill all bits
    for (int k = 0; k < 8; k++) sendChar(4'h7, 1'b0);
    chk("R6", "holdReg full", holdReg, 24'hFFFFFF);
    sendChar(4'h9, 1'b0);
    chk("R7", "instrReg", instrReg, 24'hFFFFFF);
    sendChar(4'hA, 1'b0);
    chk("R8", "instrReg wrap", instrReg, 24'h000000);
    chk("R8", "accReg", accReg, 24'hFFFFFF);

    // R12 master reset from wait
    @(negedge clk) masterReset = 1'b1;
    @(negedge clk) masterReset = 1'b0;
    checkRegs("R12", 24'h0, 24'h0, 24'h0);
    chk("R12", "loadMode", {22'b0, loadMode}, 24'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule